// File: doc/BRIEF.md
# Dual-Slot Packet Header Checker

This block sits on the receive side of a wide streaming header bus. Each cycle the bus carries 32 header bytes and can hold up to two packet headers. The slots are anchored at byte 0 and byte 16. Each slot has its own valid bit and its own two-byte info field. The block decodes each valid slot: flow-control class, virtual channel, header length in dwords, data-attached flag and an optional parity bit. One cycle after the input it presents one decoded record per slot, in slot order.

Alongside the decode, the block checks the rules that tie the two slots together:

- The first header of a transfer must start in slot 0.
- A header longer than 16 bytes takes the whole bus.
- Only a limited number of distinct class/channel pairs may appear in one cycle.
- When enabled, parity must match.

Any broken rule sets a fatal-error output. That output stays set until reset. Downstream logic reads the records; the error goes to a fatal-error collector.

Top module: `hdr_slot_checker`

## Requirements
- R1: A transfer with the slot-1 valid bit set and the slot-0 valid bit clear is a violation.
- R2: For slot s, the info field is info_bus[16s+15:16s]. Its bits 3:0 give the flow-control class and its bits 7:4 give the virtual channel. These appear on rec_fc[4s+3:4s] and rec_vc[4s+3:4s].
- R3: Bits 12:8 of a slot's info field give the header length in dwords, shown on rec_dw[5s+4:5s]. Bit 14 is the data-attached flag, shown on rec_data[s]. Bit 15 is parity. Bit 13 is reserved: it changes no record and is never a violation on its own.
- R4: With PARITY_EN set, the parity bit of a valid slot must equal the XOR of every other info bit of that slot and of every bit in the header's own bytes. Those are the length×4 bytes starting at the slot anchor. A mismatch is a violation.
- R5: A header in slot 0 longer than 4 dwords while slot 1 is valid is a violation. So is any slot-0 header longer than 8 dwords, and any slot-1 header longer than 4 dwords.
- R6: More than MAX_FC_VC distinct class/channel pairs among the valid slots of one cycle is a violation. The default MAX_FC_VC is 1.
- R7: Records appear exactly one cycle after the input: rec_vld equals the previous hdr_vld, and each field reflects its own slot.
- R8: rec_rank[s] is 1 when slot s is valid and a lower slot is valid in the same transfer, which marks it as ordered behind that lower slot.
- R9: err_fatal rises one cycle after a violation and stays high until reset. Synchronous active-low reset clears err_fatal, rec_vld and rec_rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_vld | input | NUM_SLOTS (2) | Header start per slot |
| hdr_bus | input | HDR_BYTES*8 (256) | Header bytes, byte 0 in bits 7:0 |
| info_bus | input | NUM_SLOTS*16 (32) | Two info bytes per slot |
| rec_vld | output | NUM_SLOTS | Registered slot valid |
| rec_fc | output | NUM_SLOTS*4 | Flow-control class per slot |
| rec_vc | output | NUM_SLOTS*4 | Virtual channel per slot |
| rec_dw | output | NUM_SLOTS*5 | Header length in dwords per slot |
| rec_data | output | NUM_SLOTS | Data-attached flag per slot |
| rec_rank | output | NUM_SLOTS | Slot is ordered behind a lower slot |
| err_fatal | output | 1 | Sticky fatal rule violation |

## Verification
The bench fills the header bytes that lie beyond a header's length with random values. A design that took parity over the whole slot, or over the fixed 16 bytes, would then raise false errors on legal traffic.

It drives 5-dword headers alone and next to a slot-1 header. A design that ignored the claim on both slots would miss the collision.

Two headers with different class/channel pairs must trip the default pair limit, while two with the same pair must pass. A count that treated repeated pairs as distinct would fail one of these two cases.

Every violation is followed by further legal cycles, which exposes an error flag that clears itself. The reserved bit is toggled on legal traffic, which shows whether the design wrongly decodes it.

// File: rtl/hsc_pkg.sv
// Shared types for the dual-slot header checker.
// Assumes a 16-bit info field per slot with the layout listed in the brief.
package hsc_pkg;

    typedef struct packed {
        logic       par;
        logic       has_data;
        logic       rsvd;
        logic [4:0] dw;
        logic [3:0] vc;
        logic [3:0] fc;
    } slot_info_t;

    typedef struct packed {
        logic       vld;
        logic [3:0] fc;
        logic [3:0] vc;
        logic [4:0] dw;
        logic       has_data;
        logic       par_bad;
    } slot_dec_t;

endpackage

// File: rtl/hsc_slot_decode.sv
// Decodes one header slot: splits its info field and checks parity over the
// header's own dwords (from the slot anchor, length taken from the info field).
// Assumes SLOT_IDX*SLOT_BYTES is dword aligned and lies inside the bus.
module hsc_slot_decode #(
    parameter int SLOT_IDX   = 0,
    parameter int SLOT_BYTES = 16,
    parameter int HDR_BYTES  = 32,
    parameter bit PARITY_EN  = 1'b1
) (
    input  logic                   vld,
    input  logic [HDR_BYTES*8-1:0] hdr_bus,
    input  logic [15:0]            info_raw,
    output hsc_pkg::slot_dec_t     dec
);
    localparam int BASE    = SLOT_IDX * SLOT_BYTES;
    localparam int SPAN_DW = (HDR_BYTES - BASE) / 4;

    hsc_pkg::slot_info_t info;
    logic [SPAN_DW-1:0]  dw_par;
    logic [SPAN_DW-1:0]  dw_in;
    logic                par_calc;

    assign info = hsc_pkg::slot_info_t'(info_raw);

    // Per-dword parity and membership of each dword in this header.
    for (genvar d = 0; d < SPAN_DW; d++) begin : g_dw
        assign dw_par[d] = ^hdr_bus[(BASE + 4*d)*8 +: 32];
        assign dw_in[d]  = (info.dw > 5'(d));
    end

    // Expected parity: covered header bits plus all non-parity info bits.
    assign par_calc = (^(dw_par & dw_in)) ^ (^info_raw[14:0]);

    // Assemble the decoded record for this slot.
    always_comb begin
        dec          = '0;
        dec.vld      = vld;
        dec.fc       = info.fc;
        dec.vc       = info.vc;
        dec.dw       = info.dw;
        dec.has_data = info.has_data;
        dec.par_bad  = PARITY_EN && vld && (par_calc != info.par);
    end
endmodule

// File: rtl/hsc_slot_rules.sv
// Cross-slot rule check on decoded slots: start position, header room,
// distinct class/channel pair limit and parity. Purely combinational.
// Assumes slot s is anchored at s*SLOT_BYTES.
module hsc_slot_rules #(
    parameter int NUM_SLOTS  = 2,
    parameter int SLOT_BYTES = 16,
    parameter int HDR_BYTES  = 32,
    parameter int MAX_FC_VC  = 1
) (
    input  hsc_pkg::slot_dec_t [NUM_SLOTS-1:0] dec,
    output logic                               viol
);
    logic gap, over, par;
    int   pairs;

    // Walk the slots in order and collect every rule breach.
    always_comb begin
        gap   = 1'b0;
        over  = 1'b0;
        par   = 1'b0;
        pairs = 0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            int  lim;
            logic fresh;
            if (dec[s].vld && !dec[0].vld) gap = 1'b1;
            lim = HDR_BYTES - s*SLOT_BYTES;
            for (int t = NUM_SLOTS-1; t > s; t--) begin
                if (dec[t].vld) lim = (t - s) * SLOT_BYTES;
            end
            if (dec[s].vld && (int'(dec[s].dw) * 4 > lim)) over = 1'b1;
            if (dec[s].par_bad) par = 1'b1;
            fresh = dec[s].vld;
            for (int t = 0; t < s; t++) begin
                if (dec[t].vld && dec[t].fc == dec[s].fc && dec[t].vc == dec[s].vc)
                    fresh = 1'b0;
            end
            if (fresh) pairs = pairs + 1;
        end
        viol = gap | over | par | (pairs > MAX_FC_VC);
    end
endmodule

// File: rtl/hdr_slot_checker.sv
// Dual-slot header checker top: decodes each slot, checks cross-slot rules,
// registers records one cycle after input, keeps a sticky fatal error.
// Assumes HDR_BYTES is a multiple of SLOT_BYTES and at least two slots.
module hdr_slot_checker #(
    parameter int HDR_BYTES  = 32,
    parameter int SLOT_BYTES = 16,
    parameter int MAX_FC_VC  = 1,
    parameter bit PARITY_EN  = 1'b1,
    localparam int NUM_SLOTS = HDR_BYTES / SLOT_BYTES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SLOTS-1:0]     hdr_vld,
    input  logic [HDR_BYTES*8-1:0]   hdr_bus,
    input  logic [NUM_SLOTS*16-1:0]  info_bus,
    output logic [NUM_SLOTS-1:0]     rec_vld,
    output logic [NUM_SLOTS*4-1:0]   rec_fc,
    output logic [NUM_SLOTS*4-1:0]   rec_vc,
    output logic [NUM_SLOTS*5-1:0]   rec_dw,
    output logic [NUM_SLOTS-1:0]     rec_data,
    output logic [NUM_SLOTS-1:0]     rec_rank,
    output logic                     err_fatal
);
    hsc_pkg::slot_dec_t [NUM_SLOTS-1:0] dec;
    logic [NUM_SLOTS-1:0]               rank_nxt;
    logic                               viol;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        hsc_slot_decode #(
            .SLOT_IDX  (s),
            .SLOT_BYTES(SLOT_BYTES),
            .HDR_BYTES (HDR_BYTES),
            .PARITY_EN (PARITY_EN)
        ) u_dec (
            .vld     (hdr_vld[s]),
            .hdr_bus (hdr_bus),
            .info_raw(info_bus[16*s +: 16]),
            .dec     (dec[s])
        );
        if (s == 0) begin : g_first
            assign rank_nxt[s] = 1'b0;
        end else begin : g_later
            assign rank_nxt[s] = hdr_vld[s] && (|hdr_vld[s-1:0]);
        end
    end

    hsc_slot_rules #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BYTES(SLOT_BYTES),
        .HDR_BYTES (HDR_BYTES),
        .MAX_FC_VC (MAX_FC_VC)
    ) u_rules (
        .dec (dec),
        .viol(viol)
    );

    // Register per-slot records one cycle after the input transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_vld  <= '0;
            rec_rank <= '0;
            rec_fc   <= '0;
            rec_vc   <= '0;
            rec_dw   <= '0;
            rec_data <= '0;
        end else begin
            rec_vld  <= hdr_vld;
            rec_rank <= rank_nxt;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                rec_fc[4*s +: 4] <= dec[s].fc;
                rec_vc[4*s +: 4] <= dec[s].vc;
                rec_dw[5*s +: 5] <= dec[s].dw;
                rec_data[s]      <= dec[s].has_data;
            end
        end
    end

    // Sticky fatal error: set on any violation, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_fatal <= 1'b0;
        else if (viol) err_fatal <= 1'b1;
    end

    // R1: slot 1 without slot 0 must raise the error.
    a_r1_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld[1] && !hdr_vld[0]) |=> err_fatal);

    // R5: a long slot-0 header beside a slot-1 header must raise the error.
    a_r5_long_header: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld[0] && hdr_vld[1] && info_bus[12:8] > 5'd4) |=> err_fatal);

    // R6: two different pairs over a limit of one must raise the error.
    a_r6_pair_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (MAX_FC_VC < 2 && hdr_vld[0] && hdr_vld[1] && info_bus[7:0] != info_bus[23:16])
        |=> err_fatal);

    // R7: records follow the input valid bits by one cycle.
    a_r7_record_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rec_vld == $past(hdr_vld));

    // R8: a ranked record always has an earlier record beside it.
    a_r8_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rank[1] |-> rec_vld[0] && rec_vld[1]);

    // R9: the error stays set until reset.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_fatal |=> err_fatal);
endmodule

// File: tb/hdr_slot_checker_bench.sv
module hdr_slot_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   hdr_vld = '0;
    logic [255:0] hdr_bus = '0;
    logic [31:0]  info_bus = '0;
    logic [1:0]   rec_vld, rec_data, rec_rank;
    logic [7:0]   rec_fc, rec_vc;
    logic [9:0]   rec_dw;
    logic         err_fatal;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  model_err = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_slot_checker #(.MAX_FC_VC(MAXP)) u_hdr_slot_checker (
        .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_bus(hdr_bus),
        .info_bus(info_bus), .rec_vld(rec_vld), .rec_fc(rec_fc), .rec_vc(rec_vc),
        .rec_dw(rec_dw), .rec_data(rec_data), .rec_rank(rec_rank),
        .err_fatal(err_fatal)
    );

    // Parity per R4: other info bits plus the header's own length*4 bytes.
    function automatic logic calc_par(logic [255:0] h, logic [15:0] inf, int slot);
        logic p = ^inf[14:0];
        int base = slot * 16;
        for (int b = 0; b < 4 * int'(inf[12:8]); b++)
            if (base + b < 32) p ^= ^h[(base + b)*8 +: 8];
        return p;
    endfunction

    // Violation model from R1, R4, R5, R6.
    function automatic bit exp_viol(logic [1:0] v, logic [255:0] h, logic [31:0] inf);
        bit e = 0;
        if (v[1] && !v[0]) e = 1;                                     // R1
        if (v[0] && int'(inf[12:8]) * 4 > (v[1] ? 16 : 32)) e = 1;    // R5
        if (v[1] && inf[28:24] > 5'd4) e = 1;                         // R5
        for (int s = 0; s < 2; s++)                                   // R4
            if (v[s] && inf[16*s+15] != calc_par(h, inf[16*s +: 16], s)) e = 1;
        if (v == 2'b11 && inf[7:0] != inf[23:16] && MAXP < 2) e = 1;  // R6
        return e;
    endfunction

    function automatic logic [15:0] mk_info(logic [3:0] fc, logic [3:0] vc,
                                            logic [4:0] dw, logic dat, logic rs);
        return {1'b0, dat, rs, dw, vc, fc};
    endfunction

    function automatic logic [255:0] rnd_hdr();
        logic [255:0] h;
        for (int i = 0; i < 8; i++) h[32*i +: 32] = $urandom;
        return h;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one transfer, then check records and error after the edge.
    task automatic send(logic [1:0] v, logic [255:0] h, logic [31:0] inf);
        bit [1:0] rk;
        @(negedge clk);
        hdr_vld = v; hdr_bus = h; info_bus = inf;
        if (exp_viol(v, h, inf)) model_err = 1'b1;
        @(posedge clk); #1;
        rk = {v[1] & v[0], 1'b0};
        check(rec_vld == v, "R7", "rec_vld", rec_vld, v);
        check(rec_rank == rk, "R8", "rec_rank", rec_rank, rk);
        for (int s = 0; s < 2; s++) if (v[s]) begin
            check(rec_fc[4*s +: 4] == inf[16*s +: 4] && rec_vc[4*s +: 4] == inf[16*s+4 +: 4],
                  "R2", "fc/vc", {rec_vc, rec_fc}, inf);
            check(rec_dw[5*s +: 5] == inf[16*s+8 +: 5] && rec_data[s] == inf[16*s+14],
                  "R3", "dw/data", {rec_data, rec_dw}, inf);
        end
        check(err_fatal == model_err, "R9", "err_fatal", err_fatal, model_err);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hdr_vld = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_err = 1'b0;
        #1;
        check(err_fatal == 0 && rec_vld == 0 && rec_rank == 0, "R9", "reset state",
              {err_fatal, rec_vld, rec_rank}, 0);
    endtask

    // Build a legal transfer of a random kind with correct parity.
    task automatic legal(output logic [1:0] v, output logic [255:0] h, output logic [31:0] inf);
        int kind = $urandom_range(0, 3);
        logic [3:0] fc = 4'($urandom), vc = 4'($urandom);
        h = rnd_hdr();
        inf = '0;
        case (kind)
            0: v = 2'b00;
            1: begin v = 2'b01; inf[15:0] = mk_info(fc, vc, 5'($urandom_range(1,4)), 1'($urandom), 1'($urandom)); end
            2: begin v = 2'b11;
                   inf[15:0]  = mk_info(fc, vc, 5'($urandom_range(1,4)), 1'($urandom), 1'($urandom));
                   inf[31:16] = mk_info(fc, vc, 5'($urandom_range(1,4)), 1'($urandom), 1'($urandom)); end
            default: begin v = 2'b01; inf[15:0] = mk_info(fc, vc, 5'($urandom_range(5,8)), 1'($urandom), 1'($urandom)); end
        endcase
        for (int s = 0; s < 2; s++) inf[16*s+15] = calc_par(h, inf[16*s +: 16], s);
    endtask

    initial begin
        logic [1:0]   v;
        logic [255:0] h;
        logic [31:0]  inf;
        void'($urandom(32'h5EED_1234));
        for (int trial = 0; trial < 20; trial++) begin
            do_reset();
            for (int c = 0; c < 30; c++) begin
                legal(v, h, inf);
                send(v, h, inf);
            end
            check(err_fatal == 0, "R4", "legal traffic raised error", err_fatal, 0);
            // R3: reserved bit toggled on a legal header leaves no error.
            h = rnd_hdr();
            inf = {16'h0, mk_info(4'h3, 4'h2, 5'd4, 1'b1, 1'b1)};
            inf[15] = calc_par(h, inf[15:0], 0);
            send(2'b01, h, inf);
            check(err_fatal == 0 && rec_dw[4:0] == 5'd4, "R3", "reserved bit effect",
                  {err_fatal, rec_dw}, 4);
            // One violation per trial, kind chosen by trial number.
            h = rnd_hdr();
            inf = {mk_info(4'h1, 4'h0, 5'd4, 1'b0, 1'b0), mk_info(4'h1, 4'h0, 5'd4, 1'b0, 1'b0)};
            case (trial % 6)
                0: v = 2'b10;                                          // R1
                1: begin v = 2'b11; inf[12:8] = 5'd5; end              // R5 long + slot 1
                2: begin v = 2'b01; inf[12:8] = 5'd9; end              // R5 over whole bus
                3: begin v = 2'b11; inf[19:16] = 4'h2; end             // R6 two pairs
                4: v = 2'b11;                                          // R4 parity flipped below
                default: begin v = 2'b11; inf[28:24] = 5'd6; end       // R5 slot 1 too long
            endcase
            for (int s = 0; s < 2; s++) inf[16*s+15] = calc_par(h, inf[16*s +: 16], s);
            if (trial % 6 == 4) inf[31] = ~inf[31];
            send(v, h, inf);
            check(err_fatal == 1, (trial % 6 == 0) ? "R1" : (trial % 6 == 3) ? "R6" :
                  (trial % 6 == 4) ? "R4" : "R5", "violation missed", err_fatal, 1);
            for (int c = 0; c < 3; c++) begin
                legal(v, h, inf);
                send(v, h, inf);
            end
            check(err_fatal == 1, "R9", "error not sticky", err_fatal, 1);
        end
        // R6: two headers sharing one pair stay legal under the limit.
        do_reset();
        h = rnd_hdr();
        inf = {mk_info(4'h7, 4'h5, 5'd3, 1'b1, 1'b0), mk_info(4'h7, 4'h5, 5'd4, 1'b0, 1'b0)};
        for (int s = 0; s < 2; s++) inf[16*s+15] = calc_par(h, inf[16*s +: 16], s);
        send(2'b11, h, inf);
        check(err_fatal == 0, "R6", "same pair flagged", err_fatal, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule